// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block turns the raw per-stage decisions of a nine-stage pipelined converter into one corrected 10-bit output word. The first eight stages each deliver a redundant three-level code from a pair of comparators. The last stage is a plain 2-bit flash. Because a sample moves one stage down the analog pipeline every half period of the converter clock, the decisions for one sample arrive on successive ticks of a double-rate clock. The block delays each stage's code so that the nine codes of one sample meet in the same tick. It then adds them with weights that halve from stage to stage and overlap by one bit, and adds a fixed offset. The result is an offset-binary word. Comparator offsets of less than a quarter of a stage's range are absorbed this way, so no output code is lost.

The block runs entirely on the double-rate clock. A strobe marks the tick on which a sample's first-stage decision is present, and a matching strobe marks the corrected word at the output. The analog stages, the comparators and the reference are outside the block.

Top module: `pipe_adc_corrector`

## Requirements
- R1: The code of stage k (k = 1..9) for a sample is taken from bits [2k-1:2k-2] of `stage_code_i`, k-1 ticks after the tick in which `valid_i` is high for that sample. Inputs on other ticks do not affect that sample's result.
- R2: A redundant stage code 2'b00 counts as -1, 2'b01 as 0 and 2'b10 as +1. Stage k (k = 1..8) is weighted 2^(9-k). The final 2-bit code is added unsigned with weight 1, and a fixed offset of 510 is added, so that all-zero redundant codes with a final code of 2'b10 give 10'h200.
- R3: A redundant stage code of 2'b11 is illegal. It is summed as 2'b10, and `code_err_o` is high in the same tick as that sample's `valid_o`. `code_err_o` stays low for samples with only legal codes, and the final stage's code 2'b11 is legal. `code_err_o` is never high without `valid_o`.
- R4: The sum is clamped to 0..1023. All redundant codes +1 with final code 3 give 1023. All -1 with final code 0 give 0. An input far beyond full scale saturates at the matching end and does not wrap.
- R5: `valid_o` is high exactly 10 ticks (five converter clock periods) after each `valid_i`, once per accepted sample, and at no other time.
- R6: A synchronous reset drops `valid_o` on the next tick and discards every sample still in flight.
- R7: A new sample may be accepted on every tick. Back-to-back samples each produce their own correct word.
- R8: With each comparator threshold shifted by less than a quarter of the stage range, every output is within one code of the ideal quantization of the input, and a slow ramp over full scale produces every one of the 1024 output codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock, one tick per half converter period |
| srst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Marks the tick holding a new sample's first-stage code |
| stage_code_i | input | 18 | Nine 2-bit stage codes, stage k in bits [2k-1:2k-2] |
| valid_o | output | 1 | Corrected word present |
| data_o | output | 10 | Corrected offset-binary word |
| code_err_o | output | 1 | The sample on the output carried an illegal redundant code |

## Verification
A sample launched with `valid_i` in tick t has its stage-k code driven in tick t+k-1. Its word, strobe and error flag appear together in tick t+10: eight ticks of alignment, one alignment register and one output register. The bench keeps a 16-entry ring indexed by tick, filled at launch time with the expected result for tick t+10. It drives inputs and reads outputs at the falling edge, so every tick compares the strobe with the ring, and the word and flag as well whenever a result is due. A reset clears every pending entry in the ring, so any strobe appearing afterwards is reported against R6.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    // Three-level decision of a redundant stage, two bits wide
    typedef logic [1:0] stage_code_t;

    localparam stage_code_t CODE_NEG  = 2'b00;  // -1
    localparam stage_code_t CODE_ZERO = 2'b01;  //  0
    localparam stage_code_t CODE_POS  = 2'b10;  // +1
    localparam stage_code_t CODE_BAD  = 2'b11;  // illegal, summed as +1

endpackage

// File: rtl/adc_corr_align.sv
// Skews the stage codes so the nine decisions of one sample meet in one tick.
// Stage s (0-based) waits NUM_STG-1-s ticks; the sample strobe waits as stage 0.
module adc_corr_align #(
    parameter int NUM_STG = 9
) (
    input  logic                 clk_i,
    input  logic                 srst_i,
    input  logic                 valid_i,
    input  logic [2*NUM_STG-1:0] code_i,
    output logic                 valid_o,
    output logic [2*NUM_STG-1:0] code_o
);
    import adc_corr_pkg::*;

    localparam int SKEW = NUM_STG - 1;

    // strobe lane, reset so no stale sample survives
    logic vsh [SKEW];

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            for (int i = 0; i < SKEW; i++) vsh[i] <= 1'b0;
        end else begin
            vsh[0] <= valid_i;
            for (int i = 1; i < SKEW; i++) vsh[i] <= vsh[i-1];
        end
    end

    assign valid_o = vsh[SKEW-1];

    // one delay line per stage, its length set by the stage position
    for (genvar s = 0; s < NUM_STG; s++) begin : g_lane
        localparam int DLY = NUM_STG - 1 - s;
        if (DLY == 0) begin : g_direct
            assign code_o[2*s +: 2] = code_i[2*s +: 2];
        end else begin : g_delay
            stage_code_t sh [DLY];
            always_ff @(posedge clk_i) begin
                sh[0] <= code_i[2*s +: 2];
                for (int i = 1; i < DLY; i++) sh[i] <= sh[i-1];
            end
            assign code_o[2*s +: 2] = sh[DLY-1];
        end
    end

endmodule

// File: rtl/adc_corr_sum.sv
// Overlapped weighted sum of one sample's aligned stage codes, offset and clamp.
module adc_corr_sum #(
    parameter int NUM_STG = 9,
    parameter int OUT_W   = 10
) (
    input  logic [2*NUM_STG-1:0] codes_i,
    output logic [OUT_W-1:0]     word_o,
    output logic                 bad_o
);
    import adc_corr_pkg::*;

    localparam int N_RED  = NUM_STG - 1;              // redundant stages
    localparam int SUM_W  = OUT_W + 2;                // room for sign and overrange
    localparam int OFFSET = (2 ** (OUT_W - 1)) - 2;   // mid-scale lands on half range
    localparam int MAXV   = (2 ** OUT_W) - 1;

    logic [SUM_W-1:0] acc;
    stage_code_t      c;

    always_comb begin
        acc   = SUM_W'(OFFSET) + SUM_W'(codes_i[2*N_RED +: 2]);
        bad_o = 1'b0;
        c     = CODE_ZERO;
        for (int s = 0; s < N_RED; s++) begin
            c = codes_i[2*s +: 2];
            unique case (c)
                CODE_NEG:  acc = acc - (SUM_W'(1) << (N_RED - s));
                CODE_ZERO: acc = acc;
                CODE_POS:  acc = acc + (SUM_W'(1) << (N_RED - s));
                CODE_BAD: begin
                    acc   = acc + (SUM_W'(1) << (N_RED - s));
                    bad_o = 1'b1;
                end
            endcase
        end
    end

    // two's-complement sign in the top bit; clamp both ends
    always_comb begin
        if (acc[SUM_W-1])
            word_o = '0;
        else if (acc > SUM_W'(MAXV))
            word_o = OUT_W'(MAXV);
        else
            word_o = acc[OUT_W-1:0];
    end

endmodule

// File: rtl/pipe_adc_corrector.sv
// Digital correction for a pipelined converter: alignment (NUM_STG-1 ticks),
// alignment register (1 tick), summing and output register (1 tick).
module pipe_adc_corrector #(
    parameter int NUM_STG = 9,
    parameter int OUT_W   = 10
) (
    input  logic                 clk_i,
    input  logic                 srst_i,
    input  logic                 valid_i,
    input  logic [2*NUM_STG-1:0] stage_code_i,
    output logic                 valid_o,
    output logic [OUT_W-1:0]     data_o,
    output logic                 code_err_o
);
    localparam int CODES_W = 2 * NUM_STG;

    logic               al_valid;
    logic [CODES_W-1:0] al_codes;

    adc_corr_align #(
        .NUM_STG (NUM_STG)
    ) u_align (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .valid_i (valid_i),
        .code_i  (stage_code_i),
        .valid_o (al_valid),
        .code_o  (al_codes)
    );

    // alignment register: cuts the skew lanes from the adder
    logic               hold_valid;
    logic [CODES_W-1:0] hold_codes;

    always_ff @(posedge clk_i) begin
        if (srst_i) hold_valid <= 1'b0;
        else        hold_valid <= al_valid;
    end

    always_ff @(posedge clk_i) begin
        hold_codes <= al_codes;
    end

    logic [OUT_W-1:0] sum_word;
    logic             sum_bad;

    adc_corr_sum #(
        .NUM_STG (NUM_STG),
        .OUT_W   (OUT_W)
    ) u_sum (
        .codes_i (hold_codes),
        .word_o  (sum_word),
        .bad_o   (sum_bad)
    );

    // output register: strobe and flag reset, word free-running
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            valid_o    <= 1'b0;
            code_err_o <= 1'b0;
        end else begin
            valid_o    <= hold_valid;
            code_err_o <= hold_valid & sum_bad;
        end
    end

    always_ff @(posedge clk_i) begin
        data_o <= sum_word;
    end

endmodule

// File: rtl/pipe_adc_corrector_chk.sv
module pipe_adc_corrector_chk #(
    parameter int NUM_STG = 9
) (
    input logic clk_i,
    input logic srst_i,
    input logic valid_i,
    input logic valid_o,
    input logic code_err_o
);
    localparam int LAT = NUM_STG + 1;
    localparam int PW  = $clog2(LAT + 2) + 1;

    // samples accepted but not yet delivered
    logic [PW-1:0] pending;

    always_ff @(posedge clk_i) begin
        if (srst_i) pending <= '0;
        else        pending <= pending + PW'(valid_i) - PW'(valid_o);
    end

    a_r6_reset_clears: assert property (@(posedge clk_i)
        srst_i |=> !valid_o);

    a_r3_flag_with_sample: assert property (@(posedge clk_i) disable iff (srst_i)
        code_err_o |-> valid_o);

    a_r5_no_orphan_output: assert property (@(posedge clk_i) disable iff (srst_i)
        valid_o |-> (pending != '0));

    a_r5_inflight_bound: assert property (@(posedge clk_i) disable iff (srst_i)
        pending <= PW'(LAT));

endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(
    .NUM_STG (NUM_STG)
) u_chk (
    .clk_i      (clk_i),
    .srst_i     (srst_i),
    .valid_i    (valid_i),
    .valid_o    (valid_o),
    .code_err_o (code_err_o)
);

// File: tb/pipe_adc_corrector_tb.sv
`timescale 1ns/1ps
module pipe_adc_corrector_tb;
    localparam int NS   = 9;
    localparam int OW   = 10;
    localparam int LAT  = 10;
    localparam int RING = 16;

    typedef logic [1:0] cvec_t [NS];

    logic            clk = 1'b0;
    logic            srst_i = 1'b1;
    logic            valid_i = 1'b0;
    logic [2*NS-1:0] stage_code_i = '0;
    logic            valid_o;
    logic [OW-1:0]   data_o;
    logic            code_err_o;

    always #4 clk = ~clk;

    pipe_adc_corrector #(.NUM_STG(NS), .OUT_W(OW)) u_dut (
        .clk_i        (clk),
        .srst_i       (srst_i),
        .valid_i      (valid_i),
        .stage_code_i (stage_code_i),
        .valid_o      (valid_o),
        .data_o       (data_o),
        .code_err_o   (code_err_o)
    );

    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    bit          done = 0;
    cvec_t       cring [RING];
    bit          sring [RING];
    bit          ev    [RING];
    int          evl   [RING];
    int          etol  [RING];
    bit          eerr  [RING];
    string       ereq  [RING];
    string       vreq = "R5";
    bit          track_hits = 0;
    bit          hits [1024];
    real         thi [NS-1];
    real         tlo [NS-1];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at tick %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // expected word from the code rules (R2, R3, R4)
    function automatic int code_sum(input cvec_t cd);
        int a;
        a = 510 + int'(cd[NS-1]);
        for (int s = 0; s < NS-1; s++) begin
            if (cd[s] == 2'b00)      a -= (1 << (8 - s));
            else if (cd[s] != 2'b01) a += (1 << (8 - s));
        end
        if (a < 0) a = 0;
        if (a > 1023) a = 1023;
        return a;
    endfunction

    function automatic bit has_bad(input cvec_t cd);
        for (int s = 0; s < NS-1; s++) if (cd[s] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int ideal(input real x);
        int v;
        v = int'($floor(x + 512.0));
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    // behavioural stage chain with shifted thresholds
    task automatic quantize(input real x, output cvec_t cd);
        real r;
        int  d, f;
        r = x;
        for (int k = 0; k < NS-1; k++) begin
            if (r > thi[k])      d = 1;
            else if (r < tlo[k]) d = -1;
            else                 d = 0;
            cd[k] = 2'(d + 1);
            r = 2.0 * (r - 256.0 * d);
        end
        f = int'($floor(r / 256.0)) + 2;
        if (f < 0) f = 0;
        if (f > 3) f = 3;
        cd[NS-1] = 2'(f);
    endtask

    function automatic cvec_t rand_legal();
        cvec_t cd;
        for (int s = 0; s < NS-1; s++) cd[s] = 2'($urandom % 3);
        cd[NS-1] = 2'($urandom % 4);
        return cd;
    endfunction

    // one tick: check the outputs due now, then drive this tick's inputs
    task automatic step(input bit launch, input cvec_t cd, input int val, input int tol,
                        input bit err, input string req, input bit rst);
        int slot, oslot, idx, d;
        @(negedge clk);
        slot = int'(cyc % RING);
        chk(valid_o === ev[slot], vreq, "valid_o", int'(valid_o), int'(ev[slot]));
        if (ev[slot] && valid_o === 1'b1) begin
            d = int'(data_o) - evl[slot];
            if (d < 0) d = -d;
            chk(d <= etol[slot], ereq[slot], "data_o", int'(data_o), evl[slot]);
            chk(code_err_o === eerr[slot], "R3", "code_err_o", int'(code_err_o), int'(eerr[slot]));
            if (track_hits) hits[data_o] = 1'b1;
        end else if (!ev[slot]) begin
            chk(code_err_o === 1'b0, "R3", "code_err_o idle", int'(code_err_o), 0);
        end
        ev[slot] = 1'b0;
        srst_i  = rst;
        valid_i = launch && !rst;
        sring[slot] = valid_i;
        if (valid_i) begin
            cring[slot] = cd;
            oslot = int'((cyc + LAT) % RING);
            ev[oslot]   = 1'b1;
            evl[oslot]  = val;
            etol[oslot] = tol;
            eerr[oslot] = err;
            ereq[oslot] = req;
        end
        for (int s = 0; s < NS; s++) begin
            idx = int'((cyc + RING - s) % RING);
            if (cyc >= s && sring[idx]) stage_code_i[2*s +: 2] = cring[idx][s];
            else                        stage_code_i[2*s +: 2] = 2'($urandom);
        end
        if (rst) for (int i = 0; i < RING; i++) ev[i] = 1'b0;
        cyc++;
    endtask

    cvec_t zc;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, zc, 0, 0, 1'b0, "", 1'b0);
    endtask

    task automatic send_exact(input cvec_t cd, input string req, input int gap);
        step(1'b1, cd, code_sum(cd), 0, has_bad(cd), req, 1'b0);
        idle(gap);
    endtask

    initial begin
        cvec_t cd;
        real   x;
        int    miss;
        void'($urandom(32'h1d5e_a7c3));
        for (int s = 0; s < NS; s++) zc[s] = 2'b01;
        for (int i = 0; i < RING; i++) begin
            ev[i] = 1'b0; sring[i] = 1'b0; cring[i] = zc;
        end
        for (int i = 0; i < 1024; i++) hits[i] = 1'b0;
        for (int k = 0; k < NS-1; k++) begin
            thi[k] =  128.0 + real'(int'($urandom % 201) - 100);
            tlo[k] = -128.0 + real'(int'($urandom % 201) - 100);
        end

        // R6: reset state
        vreq = "R6";
        for (int i = 0; i < 4; i++) step(1'b0, zc, 0, 0, 1'b0, "", 1'b1);
        chk(valid_o === 1'b0, "R6", "valid_o after reset", int'(valid_o), 0);
        chk(code_err_o === 1'b0, "R6", "code_err_o after reset", int'(code_err_o), 0);
        vreq = "R5";

        // R2: mid-scale and a mixed pattern
        cd = zc; cd[8] = 2'b10;
        send_exact(cd, "R2", 1);
        cd = '{2'b10, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01};
        send_exact(cd, "R2", 1);

        // R4: both ends of the code range
        for (int s = 0; s < NS-1; s++) cd[s] = 2'b10;
        cd[8] = 2'b11;
        send_exact(cd, "R4", 1);
        for (int s = 0; s < NS; s++) cd[s] = 2'b00;
        send_exact(cd, "R4", 1);

        // R3: illegal code in stage 3 and stage 8, legal 11 in the final stage
        cd = zc; cd[8] = 2'b10; cd[2] = 2'b11;
        send_exact(cd, "R3", 1);
        cd = zc; cd[8] = 2'b10; cd[7] = 2'b11;
        send_exact(cd, "R3", 1);
        cd = zc; cd[8] = 2'b11;
        send_exact(cd, "R3", 1);

        // R4: inputs far outside full scale saturate
        quantize(600.0, cd);
        step(1'b1, cd, 1023, 0, 1'b0, "R4", 1'b0); idle(1);
        quantize(-600.0, cd);
        step(1'b1, cd, 0, 0, 1'b0, "R4", 1'b0); idle(1);
        idle(12);

        // R1: random legal codes with irregular spacing
        for (int i = 0; i < 200; i++) send_exact(rand_legal(), "R1", int'($urandom % 3));

        // R7: one sample per tick
        for (int i = 0; i < 40; i++) send_exact(rand_legal(), "R7", 0);
        idle(12);

        // R8: random inputs through the offset quantizer
        for (int i = 0; i < 400; i++) begin
            x = real'(int'($urandom % 1023000)) / 1000.0 - 511.5;
            quantize(x, cd);
            step(1'b1, cd, ideal(x), 1, 1'b0, "R8", 1'b0);
            idle(1);
        end
        idle(12);

        // R6: reset with samples in flight
        for (int i = 0; i < 6; i++) send_exact(rand_legal(), "R6", 0);
        vreq = "R6";
        step(1'b0, zc, 0, 0, 1'b0, "", 1'b1);
        step(1'b0, zc, 0, 0, 1'b0, "", 1'b1);
        idle(14);
        vreq = "R5";

        // R8: ramp, every code must appear
        track_hits = 1'b1;
        for (int i = 0; i < 4096; i++) begin
            x = -512.0 + 0.125 + 0.25 * real'(i);
            quantize(x, cd);
            step(1'b1, cd, ideal(x), 1, 1'b0, "R8", 1'b0);
            idle(1);
        end
        idle(12);
        track_hits = 1'b0;
        miss = 0;
        for (int i = 0; i < 1024; i++) if (!hits[i]) miss++;
        chk(miss == 0, "R8", "missing codes", miss, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule